// File: doc/BRIEF.md
# Double-Buffered Clock Register Bank

This block is the user-facing face of a timekeeping core. It owns the eight highest byte addresses of a byte-wide memory map and keeps a set of user registers that mirror a separate running counter block. Every access below those eight addresses goes straight through to an SRAM port. The counter block itself, and the SRAM array behind the port, sit outside this block.

While neither halt bit is set, the user registers copy the counter fields on each tick pulse. All fields take their new values together in one cycle. Software may freeze the user copy in two ways, and each ends differently.

The first is a write halt. Software loads a new time into the registers and then clears the halt. Clearing it pushes all eight values into the counters through a one-cycle load strobe. The second is a read halt. It freezes the copy so that software can read a consistent set of fields. Clearing it loads nothing, and the copy catches up with the counters, which never stopped, at the next tick. The day register carries a read-only battery status bit, taken from an input.

Top module: `clkreg_bank`

## Requirements
- R1: An access is in the clock window when the top AW-3 address bits are all ones. Every other access is passed to the SRAM port in the same cycle, with its address, write data and direction. The clock window never drives the SRAM port. The read response for an SRAM read is `sram_rdata` in the response cycle.
- R2: Offset 0 is the control byte. Bit 7 is the write halt (W), bit 6 is the read halt (R), and bits 5:0 are the century. A read returns {W, R, century}. After reset all of these are zero.
- R3: While W or R is 1, no user register changes on a tick. The counters keep running outside the block.
- R4: A control write with bit 7 = 0 while W is 1 raises `load_strobe` for exactly the next cycle. In that cycle `load_time` carries every user value: byte i sits at bits 8i+7:8i, byte 0 is {2'b00, century}, and day bit 7 is 0. No tick snapshot is taken in the strobe cycle.
- R5: A control write with bit 7 or bit 6 set leaves the century unchanged. A write with both bits 0 while W is 1 stores bits 5:0 as the new century. Any other control write leaves the century unchanged.
- R6: Clearing R while W is 0 produces no load strobe and changes no field. Tracking resumes at the next tick.
- R7: With both halt bits 0 and no load strobe, a tick copies every field in one cycle. Offsets 1..7 come from `cnt_time` byte i, the century comes from `cnt_time[5:0]`, and day bit 7 is forced to 0. The new values are readable from the next cycle.
- R8: Reads of offset 4 return `battery_ok` in bit 7, sampled in the cycle the read is accepted. Writes to that bit are ignored.
- R9: `bus_ready` is always 1. A read accepted in cycle t gives `rsp_valid` = 1 with data in cycle t+1. A response cannot be stalled.
- R10: Field offsets are 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month and 7 year. A bus write to a field takes priority over a tick snapshot in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_ready | output | 1 | Request accepted (always 1) |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 8 | Read data |
| sram_valid | output | 1 | SRAM request valid |
| sram_write | output | 1 | SRAM write direction |
| sram_addr | output | AW | SRAM address |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data, one cycle after request |
| tick | input | 1 | Counter advance pulse |
| cnt_time | input | 64 | Packed counter fields, byte per offset |
| load_strobe | output | 1 | Load the counters from `load_time` |
| load_time | output | 64 | Packed user fields for loading |
| battery_ok | input | 1 | Battery status |

## Verification
The assertions assume that at most one bus operation arrives per cycle. They also assume that `tick` is a single-cycle pulse and that the SRAM answers one cycle after its request. The bench keeps to these rules by issuing one request and then returning `bus_valid` low. Its counter model raises a tick every fourth cycle and loads `load_time` whenever the strobe fires. Unused field bits are written as zero, as the usage rules require.

// File: rtl/ckb_pkg.sv
package ckb_pkg;
  localparam int NREG     = 8;
  localparam int OFF_CTRL = 0;
  localparam int OFF_DAY  = 4;
  localparam int IDXW     = $clog2(NREG);
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/ckb_decode.sv
module ckb_decode #(
  parameter int AW = 19
) (
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic [AW-1:0]            bus_addr,
  output logic [ckb_pkg::NREG-1:0] reg_wr,
  output logic                     reg_rd,
  output logic [ckb_pkg::IDXW-1:0] reg_idx,
  output logic                     sram_req
);
  import ckb_pkg::*;
  logic in_window;
  assign in_window = &bus_addr[AW-1:IDXW];
  assign reg_idx   = bus_addr[IDXW-1:0];
  assign reg_rd    = bus_valid && in_window && !bus_write;
  assign sram_req  = bus_valid && !in_window;
  always_comb begin
    reg_wr = '0;
    if (bus_valid && in_window && bus_write) reg_wr[reg_idx] = 1'b1;
  end
endmodule

// File: rtl/ckb_ctrl.sv
module ckb_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [7:0] wdata,
  input  logic       snap,
  input  logic [5:0] cnt_cent,
  output logic       w_q,
  output logic       r_q,
  output logic [5:0] cent_q,
  output logic       load_q
);
  logic clear_w, take_cent;
  assign clear_w   = ctrl_wr && w_q && !wdata[7];
  assign take_cent = clear_w && !wdata[6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_q    <= 1'b0;
      r_q    <= 1'b0;
      cent_q <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= clear_w;
      if (ctrl_wr) begin
        w_q <= wdata[7];
        r_q <= wdata[6];
        if (take_cent) cent_q <= wdata[5:0];
      end else if (snap) begin
        cent_q <= cnt_cent;
      end
    end
  end

  assert_cent_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (wdata[7] || wdata[6])) |=> $stable(cent_q));
  assert_load_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> ($past(w_q) && !w_q));
  assert_no_load_r_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !w_q) |=> !load_q);
endmodule

// File: rtl/ckb_shadow.sv
module ckb_shadow #(
  parameter bit RO_TOP = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       snap,
  input  logic [7:0] cnt_byte,
  output logic [7:0] q
);
  logic [7:0] mask;
  generate
    if (RO_TOP) begin : g_ro
      assign mask = 8'h7F;
    end else begin : g_rw
      assign mask = 8'hFF;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (wr)   q <= wdata & mask;
    else if (snap) q <= cnt_byte & mask;
  end

  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap && !wr) |=> $stable(q));
  assert_snap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snap && !wr) |=> (q[6:0] == $past(cnt_byte[6:0])));
endmodule

// File: rtl/clkreg_bank.sv
module clkreg_bank #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic          bus_ready,
  output logic          rsp_valid,
  output logic [7:0]    rsp_data,
  output logic          sram_valid,
  output logic          sram_write,
  output logic [AW-1:0] sram_addr,
  output logic [7:0]    sram_wdata,
  input  logic [7:0]    sram_rdata,
  input  logic          tick,
  input  logic [63:0]   cnt_time,
  output logic          load_strobe,
  output logic [63:0]   load_time,
  input  logic          battery_ok
);
  import ckb_pkg::*;

  logic [NREG-1:0] reg_wr;
  logic            reg_rd;
  logic [IDXW-1:0] reg_idx;
  logic            w_q, r_q, load_q, snap;
  logic [5:0]      cent_q;
  byte_t           fld   [NREG];
  byte_t           rview [NREG];
  logic            rsp_q, rsp_sram_q;
  byte_t           rsp_reg_q;

  ckb_decode #(.AW(AW)) u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx), .sram_req(sram_valid)
  );

  assign snap = tick && !w_q && !r_q && !load_q;

  ckb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(reg_wr[OFF_CTRL]), .wdata(bus_wdata),
    .snap(snap), .cnt_cent(cnt_time[5:0]), .w_q(w_q), .r_q(r_q),
    .cent_q(cent_q), .load_q(load_q)
  );

  assign fld[OFF_CTRL] = {2'b00, cent_q};

  genvar gi;
  generate
    for (gi = 1; gi < NREG; gi++) begin : g_fld
      ckb_shadow #(.RO_TOP(gi == OFF_DAY)) u_sh (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr[gi]), .wdata(bus_wdata),
        .snap(snap), .cnt_byte(cnt_time[8*gi +: 8]), .q(fld[gi])
      );
    end
    for (gi = 0; gi < NREG; gi++) begin : g_pack
      assign load_time[8*gi +: 8] = fld[gi];
      if (gi == OFF_CTRL) begin : g_c
        assign rview[gi] = {w_q, r_q, cent_q};
      end else if (gi == OFF_DAY) begin : g_d
        assign rview[gi] = {battery_ok, fld[gi][6:0]};
      end else begin : g_o
        assign rview[gi] = fld[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q      <= 1'b0;
      rsp_sram_q <= 1'b0;
      rsp_reg_q  <= '0;
    end else begin
      rsp_q      <= reg_rd || (sram_valid && !bus_write);
      rsp_sram_q <= sram_valid;
      if (reg_rd) rsp_reg_q <= rview[reg_idx];
    end
  end

  assign bus_ready   = 1'b1;
  assign rsp_valid   = rsp_q;
  assign rsp_data    = rsp_sram_q ? sram_rdata : rsp_reg_q;
  assign load_strobe = load_q;
  assign sram_write  = bus_write;
  assign sram_addr   = bus_addr;
  assign sram_wdata  = bus_wdata;

  assert_rsp_follows_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_valid && !bus_write));
endmodule

// File: tb/sim_clkreg_bank.sv
`timescale 1ns/1ps
module sim_clkreg_bank;
  localparam int AW = 19;
  localparam logic [AW-1:0] TOP = {AW{1'b1}} - AW'(7);

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic          bus_valid = 0, bus_write = 0, bus_ready, rsp_valid;
  logic [AW-1:0] bus_addr = '0, sram_addr;
  logic [7:0]    bus_wdata = 0, rsp_data, sram_wdata, sram_rdata = 8'h3C;
  logic          sram_valid, sram_write, tick = 0, load_strobe, battery_ok = 1;
  logic [63:0]   cnt_time = 64'h1122334455667708, load_time;

  clkreg_bank #(.AW(AW)) u0 (.*);

  int compared = 0, mismatched = 0, cyc = 0;
  string cur_tag = "R2";

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // counter model outside the block
  always @(posedge clk) begin
    #1;
    cyc++;
    if (load_strobe) cnt_time <= load_time;
    else if (tick) cnt_time <= cnt_time + 64'h0102030405060701;
    tick <= (cyc % 4 == 0);
  end

  // behavioural reference
  logic [7:0] m_b [8];
  logic m_w, m_r, m_load, m_rspv, m_sram;
  logic [5:0] m_cent;
  logic [7:0] m_rspd;

  function automatic logic [7:0] view(int k);
    if (k == 0) return {m_w, m_r, m_cent};
    if (k == 4) return {battery_ok, m_b[4][6:0]};
    return m_b[k];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_w <= 0; m_r <= 0; m_cent <= 0; m_load <= 0; m_rspv <= 0; m_sram <= 0; m_rspd <= 0;
      for (int k = 0; k < 8; k++) m_b[k] <= 0;
    end else begin
      automatic bit win = bus_valid && (bus_addr >= TOP);
      automatic int k = int'(bus_addr - TOP);
      automatic bit snapm = tick && !m_w && !m_r && !m_load;
      m_load <= win && bus_write && k == 0 && m_w && !bus_wdata[7];
      m_rspv <= bus_valid && !bus_write;
      m_sram <= bus_valid && !win;
      if (win && !bus_write) m_rspd <= view(k);
      if (win && bus_write && k == 0) begin
        m_w <= bus_wdata[7]; m_r <= bus_wdata[6];
        if (m_w && !bus_wdata[7] && !bus_wdata[6]) m_cent <= bus_wdata[5:0];
      end else if (snapm) m_cent <= cnt_time[5:0];
      for (int j = 1; j < 8; j++) begin
        automatic logic [7:0] mk = (j == 4) ? 8'h7F : 8'hFF;
        if (win && bus_write && k == j) m_b[j] <= bus_wdata & mk;
        else if (snapm) m_b[j] <= cnt_time[8*j +: 8] & mk;
      end
    end
  end

  function automatic logic [63:0] m_pack();
    logic [63:0] v;
    v[7:0] = {2'b00, m_cent};
    for (int j = 1; j < 8; j++) v[8*j +: 8] = m_b[j];
    return v;
  endfunction

  always @(negedge clk) if (rst_n) begin
    check("R9", bus_ready, 1);
    check("R1", sram_valid, bus_valid && (bus_addr < TOP));
    if (sram_valid) check("R1", {sram_write, sram_addr, sram_wdata}, {bus_write, bus_addr, bus_wdata});
    check("R9", rsp_valid, m_rspv);
    if (m_rspv) check(cur_tag, rsp_data, m_sram ? sram_rdata : m_rspd);
    check("R4", load_strobe, m_load);
    if (m_load) check("R4", load_time, m_pack());
  end

  task automatic op(bit wr_, logic [AW-1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    bus_valid = 1; bus_write = wr_; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask
  task automatic wr(int k, logic [7:0] d); op(1, TOP + AW'(k), d); endtask
  task automatic rd(int k); op(0, TOP + AW'(k), 0); endtask
  task automatic rd_all(); for (int k = 0; k < 8; k++) rd(k); endtask
  task automatic idle(int n); repeat (n) @(posedge clk); endtask

  bit done = 0;
  initial begin
    #(5.0 * 200000);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle(4); #1; rst_n = 1;
    cur_tag = "R2"; rd(0);                        // reset state of control byte
    cur_tag = "R7"; idle(10); rd_all(); idle(5); rd_all();
    cur_tag = "R8"; battery_ok = 0; rd(4); battery_ok = 1; rd(4);
    wr(4, 8'h83); rd(4);
    cur_tag = "R3"; wr(0, 8'h80);
    for (int k = 1; k < 8; k++) wr(k, 8'(8'h10 + k));
    cur_tag = "R10"; idle(9); rd_all();
    cur_tag = "R5"; wr(0, 8'hD5); rd(0);          // sets R with W held: century kept
    cur_tag = "R4"; wr(0, 8'h20); rd(0); idle(2); rd_all(); idle(8); rd_all();
    cur_tag = "R6"; wr(0, 8'h5F); rd(0); idle(9); rd_all();
    wr(0, 8'h11); rd(0); idle(9); rd_all();
    cur_tag = "R5"; wr(0, 8'h80); wr(0, 8'h40); rd(0); wr(0, 8'h00); rd(0);
    cur_tag = "R1";
    for (int i = 0; i < 6; i++) begin
      sram_rdata = 8'(8'hA0 + i);
      op(1, AW'(19'h00100 + i), 8'(i));
      op(0, AW'(19'h7FFF7 - i), 0);
    end
    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule